// File: doc/BRIEF.md
# Serial Peripheral Host Port with Vectored Interrupts

This block is the processor-facing side of a two-channel serial peripheral. The host drives an asynchronous bus: an active-low select, a read/write level, four address lines and an eight-bit data path. The block brings the control lines into its own clock domain and turns each bus cycle into either a one-clock register write or a captured register read. It answers every cycle with an active-low transfer acknowledge. The data path and the acknowledge are both modelled as value-plus-enable pairs. This lets the pad ring build the three-state and open-drain drivers.

The block also collects eight interrupt conditions from the rest of the peripheral. It keeps a status copy of them and a mask, and it pulls an open-drain request line low while any unmasked condition is set. In a host interrupt-acknowledge cycle, the block places its programmable vector on the data bus and acknowledges, but only if a request is pending. If no request is pending, it leaves the bus alone so that another device can respond. The block also owns the general output-port register, whose pins are driven inverted, and the counter/timer stop control.

The host interface follows the asynchronous handshake of a processor bus rather than a valid/ready stream. Back-pressure comes from the acknowledge: the host holds select (or interrupt acknowledge) asserted until it sees the acknowledge, and the block does not release the acknowledge until the host lets go.

Top module: `sio_host_port`

## Requirements
- R1: The data bus enable is asserted only while `cs_n` is low in a read cycle, or while `iack_n` is low in an acknowledged vector cycle. It drops in the same cycle that the controlling strobe rises, so the bus is high impedance whenever `cs_n` and `iack_n` are both high.
- R2: A cycle started with `rw` high is a read, and one started with `rw` low is a write. A write changes the addressed register. A read returns the addressed register on `data_out` while the acknowledge is asserted.
- R3: Address map. 0x4 is the interrupt mask (read/write). 0x5 is the interrupt status (read-only; writes are ignored). 0xC is the vector (read/write). 0xD is the output-port register (read/write). 0xE reads the timer stop flag in bit 0, and a write to it clears the flag. 0xF sets the flag on a write. Every other address reads 0x00 and ignores writes.
- R4: `ack_oe` asserts on the third rising clock edge after `cs_n` (or a pending `iack_n`) goes low, because of two synchronizer flops plus one state flop. It stays asserted until both strobes are seen high through the synchronizers.
- R5: A write produces exactly one register update. The new value is visible on the outputs by the time `ack_oe` asserts.
- R6: The status register is a registered copy of `irq_src`. `irq_pull` is asserted exactly when `status & mask` is non-zero, so it follows a change on `irq_src` one clock later.
- R7: In an interrupt-acknowledge cycle with a request pending, the block asserts `ack_oe` and drives the vector on `data_out` with `data_oe` high.
- R8: In an interrupt-acknowledge cycle with no request pending, `ack_oe` and `data_oe` both stay low for the whole cycle.
- R9: After reset, the status and mask registers read 0x00, the vector reads 0x0F, the output-port register reads 0x00 with `op_pins` all high, `timer_stop` is 1, and `irq_pull`, `ack_oe` and `data_oe` are low.
- R10: Bit k of `op_pins` is the inverse of bit k of the output-port register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from host, asynchronous |
| rw | input | 1 | 1 = read, 0 = write, sampled at cycle start |
| addr | input | 4 | Register address |
| data_in | input | 8 | Host write data |
| data_out | output | 8 | Read or vector data to host |
| data_oe | output | 1 | Data bus drive enable (else high impedance) |
| ack_oe | output | 1 | Drive acknowledge low (else high impedance) |
| iack_n | input | 1 | Active-low interrupt acknowledge from host |
| irq_src | input | 8 | Interrupt conditions from channels and timer |
| irq_pull | output | 1 | Pull open-drain request line low |
| op_pins | output | 8 | General output port pins |
| timer_stop | output | 1 | Counter/timer held stopped when 1 |

## Verification
The hardest case to reach from the ports is an interrupt-acknowledge cycle in which a condition is asserted but masked. The block must then stay fully silent, even though `irq_src` is non-zero. The random loop mixes mask writes with changes to `irq_src` and acknowledge cycles, so pending and non-pending acknowledges both occur with many different source and mask combinations. Directed cases also cover a masked-only source, writes to the read-only status address, and the exact edge on which the acknowledge rises.

// File: rtl/sio_host_pkg.sv
package sio_host_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_VEC,
    ST_QUIET
  } bus_st_t;

  localparam logic [3:0] A_MASK   = 4'h4;
  localparam logic [3:0] A_STAT   = 4'h5;
  localparam logic [3:0] A_VEC    = 4'hC;
  localparam logic [3:0] A_OPORT  = 4'hD;
  localparam logic [3:0] A_TSTART = 4'hE;
  localparam logic [3:0] A_TSTOP  = 4'hF;
endpackage

// File: rtl/sio_host_sync.sv
module sio_host_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= INIT;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sio_host_fsm.sv
module sio_host_fsm
  import sio_host_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cs_s_n,
  input  logic    rw_s,
  input  logic    iack_s_n,
  input  logic    pending,
  output bus_st_t state,
  output logic    wr_en,
  output logic    rd_cap,
  output logic    vec_cap,
  output logic    ack_oe
);
  bus_st_t nxt;
  logic    idle;

  assign idle    = (state == ST_IDLE);
  assign wr_en   = idle && !cs_s_n && !rw_s;
  assign rd_cap  = idle && !cs_s_n && rw_s;
  assign vec_cap = idle && cs_s_n && !iack_s_n && pending;

  always_comb begin
    nxt = state;
    if (idle) begin
      if (!cs_s_n)        nxt = rw_s ? ST_RD : ST_WR;
      else if (!iack_s_n) nxt = pending ? ST_VEC : ST_QUIET;
    end else if (cs_s_n && iack_s_n) begin
      nxt = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign ack_oe = (state == ST_RD) || (state == ST_WR) || (state == ST_VEC);

  // R5
  single_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R4
  ack_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_oe) |-> $past(!cs_s_n || (!iack_s_n && pending)));

  // R8
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cs_s_n && !iack_s_n && !pending) |=> !ack_oe);
endmodule

// File: rtl/sio_host_regs.sv
module sio_host_regs
  import sio_host_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [DW-1:0] VEC_RESET = 8'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] irq_src,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] vector,
  output logic [DW-1:0] op_pins,
  output logic          timer_stop,
  output logic          pending
);
  logic [DW-1:0] stat_q, mask_q, vec_q, op_q;
  logic          tstop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      mask_q  <= '0;
      vec_q   <= VEC_RESET;
      op_q    <= '0;
      tstop_q <= 1'b1;
    end else begin
      stat_q <= irq_src;
      if (wr_en) begin
        case (addr)
          A_MASK:   mask_q  <= wdata;
          A_VEC:    vec_q   <= wdata;
          A_OPORT:  op_q    <= wdata;
          A_TSTART: tstop_q <= 1'b0;
          A_TSTOP:  tstop_q <= 1'b1;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_MASK:   rdata = mask_q;
      A_STAT:   rdata = stat_q;
      A_VEC:    rdata = vec_q;
      A_OPORT:  rdata = op_q;
      A_TSTART: rdata = {{(DW-1){1'b0}}, tstop_q};
      default:  rdata = '0;
    endcase
  end

  assign vector     = vec_q;
  assign op_pins    = ~op_q;
  assign timer_stop = tstop_q;
  assign pending    = |(stat_q & mask_q);

  // R2
  vec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_VEC) |=> (vector == $past(wdata)));

  // R3
  tstop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_TSTOP) |=> timer_stop);

  // R6
  stat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1 && $past(mask_q) == '1) |-> (pending == ($past(irq_src) != '0)));
endmodule

// File: rtl/sio_host_port.sv
module sio_host_port
  import sio_host_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [DW-1:0] VEC_RESET = 8'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          ack_oe,
  input  logic          iack_n,
  input  logic [DW-1:0] irq_src,
  output logic          irq_pull,
  output logic [DW-1:0] op_pins,
  output logic          timer_stop
);
  localparam int NCTL = 3;

  logic [NCTL-1:0] ctl_s;
  logic            cs_s_n, rw_s, iack_s_n;
  bus_st_t         state;
  logic            wr_en, rd_cap, vec_cap, pending;
  logic [DW-1:0]   rdata, vector, out_q;

  sio_host_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .INIT('1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_n, rw, iack_n}),
    .q    (ctl_s)
  );
  assign {cs_s_n, rw_s, iack_s_n} = ctl_s;

  sio_host_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s_n  (cs_s_n),
    .rw_s    (rw_s),
    .iack_s_n(iack_s_n),
    .pending (pending),
    .state   (state),
    .wr_en   (wr_en),
    .rd_cap  (rd_cap),
    .vec_cap (vec_cap),
    .ack_oe  (ack_oe)
  );

  sio_host_regs #(.DW(DW), .AW(AW), .VEC_RESET(VEC_RESET)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (data_in),
    .irq_src   (irq_src),
    .rdata     (rdata),
    .vector    (vector),
    .op_pins   (op_pins),
    .timer_stop(timer_stop),
    .pending   (pending)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_q <= '0;
    else if (rd_cap)  out_q <= rdata;
    else if (vec_cap) out_q <= vector;
  end

  assign data_out = out_q;
  assign data_oe  = ((state == ST_RD) && !cs_n) || ((state == ST_VEC) && !iack_n);
  assign irq_pull = pending;

  // R1
  bus_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && iack_n) |-> !data_oe);

  // R7
  vec_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && cs_s_n && !iack_n && data_oe) |-> (data_out == vector));
endmodule

// File: tb/sio_host_port_bench.sv
module sio_host_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rw = 1'b1, iack_n = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] data_in = '0, irq_src = '0;
  logic [7:0] data_out, op_pins;
  logic       data_oe, ack_oe, irq_pull, timer_stop;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] m_mask = 8'h00, m_vec = 8'h0F, m_op = 8'h00;
  logic       m_tstop = 1'b1;

  always #5 clk = ~clk;

  sio_host_port u_sio_host_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .addr(addr),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .ack_oe(ack_oe), .iack_n(iack_n), .irq_src(irq_src),
    .irq_pull(irq_pull), .op_pins(op_pins), .timer_stop(timer_stop)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'h4: return m_mask;
      4'h5: return irq_src;
      4'hC: return m_vec;
      4'hD: return m_op;
      4'hE: return {7'b0, m_tstop};
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit exp_pend();
    return (irq_src & m_mask) != 8'h00;
  endfunction

  task automatic release_wait();
    repeat (4) @(negedge clk);
    chk(ack_oe == 1'b0, "R4 ack released", {7'b0, ack_oe}, 8'h00);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b0; addr = a; data_in = d;
    repeat (2) @(posedge clk);
    #1 chk(ack_oe == 1'b0, "R4 ack early", {7'b0, ack_oe}, 8'h00);
    @(posedge clk);
    #1 chk(ack_oe == 1'b1, "R4 ack on third edge", {7'b0, ack_oe}, 8'h01);
    chk(data_oe == 1'b0, "R1 no drive on write", {7'b0, data_oe}, 8'h00);
    case (a)
      4'h4: m_mask = d;
      4'hC: m_vec = d;
      4'hD: m_op = d;
      4'hE: m_tstop = 1'b0;
      4'hF: m_tstop = 1'b1;
      default: ;
    endcase
    chk(op_pins == ~m_op, "R5 R10 op_pins after write", op_pins, ~m_op);
    chk(timer_stop == m_tstop, "R5 R3 timer_stop after write", {7'b0, timer_stop}, {7'b0, m_tstop});
    @(negedge clk);
    cs_n = 1'b1;
    release_wait();
  endtask

  task automatic bus_rd(input logic [3:0] a);
    logic [7:0] e;
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b1; addr = a;
    e = exp_read(a);
    repeat (2) @(posedge clk);
    #1 chk(data_oe == 1'b0, "R4 no drive before ack", {7'b0, data_oe}, 8'h00);
    @(posedge clk);
    #1 chk(ack_oe && data_oe, "R2 read ack+drive", {6'b0, ack_oe, data_oe}, 8'h03);
    chk(data_out == e, "R2 R3 read data", data_out, e);
    @(negedge clk);
    cs_n = 1'b1;
    #1 chk(data_oe == 1'b0, "R1 float on cs release", {7'b0, data_oe}, 8'h00);
    release_wait();
  endtask

  task automatic bus_iack();
    bit p;
    @(negedge clk);
    iack_n = 1'b0;
    p = exp_pend();
    repeat (3) @(posedge clk);
    #1;
    if (p) begin
      chk(ack_oe && data_oe, "R7 vector ack", {6'b0, ack_oe, data_oe}, 8'h03);
      chk(data_out == m_vec, "R7 vector value", data_out, m_vec);
    end else begin
      chk(!ack_oe && !data_oe, "R8 silent iack", {6'b0, ack_oe, data_oe}, 8'h00);
    end
    @(posedge clk);
    #1 chk(ack_oe == p, "R7 R8 ack held", {7'b0, ack_oe}, {7'b0, p});
    @(negedge clk);
    iack_n = 1'b1;
    #1 chk(data_oe == 1'b0, "R1 float on iack release", {7'b0, data_oe}, 8'h00);
    release_wait();
  endtask

  task automatic set_src(input logic [7:0] s);
    @(negedge clk);
    irq_src = s;
    @(posedge clk);
    #1 chk(irq_pull == exp_pend(), "R6 irq follows", {7'b0, irq_pull}, {7'b0, exp_pend()});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset image
    chk(op_pins == 8'hFF, "R9 op_pins", op_pins, 8'hFF);
    chk(timer_stop == 1'b1, "R9 timer_stop", {7'b0, timer_stop}, 8'h01);
    chk(!irq_pull && !ack_oe && !data_oe, "R9 outputs idle",
        {5'b0, irq_pull, ack_oe, data_oe}, 8'h00);
    bus_rd(4'hC);
    bus_rd(4'h4);
    bus_rd(4'h5);
    bus_rd(4'hD);
    // R3 status is read-only, unmapped ignored
    set_src(8'h21);
    bus_wr(4'h5, 8'hFF);
    bus_rd(4'h5);
    bus_wr(4'h3, 8'h77);
    bus_rd(4'h3);
    // R8 masked source only
    bus_iack();
    bus_wr(4'h4, 8'h01);
    chk(irq_pull == 1'b1, "R6 unmasked pulls", {7'b0, irq_pull}, 8'h01);
    bus_wr(4'hC, 8'hA5);
    bus_iack();
    bus_wr(4'hE, 8'h00);
    bus_rd(4'hE);
    bus_wr(4'hF, 8'h00);
    bus_wr(4'hD, 8'h3C);
    bus_rd(4'hD);
    for (int i = 0; i < 80; i++) begin
      case ($urandom % 4)
        0: bus_wr(4'($urandom), 8'($urandom));
        1: bus_rd(4'($urandom));
        2: set_src(($urandom % 2) ? 8'h00 : 8'($urandom));
        default: bus_iack();
      endcase
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule